// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block is the byte-wide arithmetic and logic unit of a small accumulator-style controller. Each request names an operation and supplies the accumulator value, a second operand (a register value or an immediate) and the current five-bit condition word. One clock later the block presents the byte result. It also presents the updated condition word and a mask that marks which condition bits the operation wrote. A separate 16-bit product register receives the full result of an unsigned byte multiply.

All subtraction is done with one adder, as the minuend plus the inverted subtrahend plus one. The borrow forms feed the carry flag in place of that one. The carry flag therefore reads 1 for "no borrow". Every operation has a fixed set of condition bits that it writes. The remaining bits of the incoming condition word pass through unchanged. Operand fetch, destination selection and instruction decode are handled around this block.

Top module: `byte_alu`

## Requirements
- R1: A request is taken on a rising edge with `go` high. On the next edge `done` rises for one cycle, and `result`, `flags` and `fmask` take the values of that request. Without `go` they hold their values. Reset clears every output to zero.
- R2: Codes 0 (operand+acc), 1 (operand+acc+C) and 5 (operand+1) are additions. C is the carry out of bit 7, DC is the carry out of bit 3, OV is signed overflow, N is bit 7 of the result and Z marks a zero result.
- R3: Codes 2 (operand−acc), 3 (operand−acc−!C), 4 (acc−operand−!C), 6 (operand−1) and 7 (0−operand) are subtractions. C=1 means no borrow out of bit 7 and DC=1 means no borrow out of bit 3. OV is signed overflow, and N and Z are as in R2.
- R4: Codes 0 to 7 write all five condition bits (fmask 5'b11111).
- R5: Codes 8 AND, 9 OR and 10 XOR combine acc with the operand. Code 11 gives the inverted operand and code 12 passes the operand unchanged. These codes write only N and Z (fmask 5'b10100).
- R6: Code 13 rotates the operand left by one and code 14 rotates it right by one, with fmask 5'b10100. Code 15 rotates left and code 16 rotates right through the carry as one 9-bit value. C receives the bit shifted out, and the fmask is 5'b10101.
- R7: Code 17 exchanges the two nibbles of the operand and writes no condition bit.
- R8: Code 18 decimal-adjusts acc. First, 6 is added if the low nibble exceeds 9 or DC is set. Then, on that intermediate value, 0x60 is added if its high nibble exceeds 9 or C is set. C becomes the old C OR any carry out of bit 7, and only C is written (fmask 5'b00001).
- R9: Code 19 multiplies acc by the operand, unsigned, into the 16-bit `prod`. `result` is the low byte of the product and no condition bit is written.
- R10: `prod` changes only on a code 19 request and keeps its value across all other requests.
- R11: The condition word is ordered {N, OV, Z, DC, C} from bit 4 down to bit 0. `flags` carries the new value in each bit set in `fmask` and the `stat_in` bit in every other position.
- R12: Codes 20 to 31 are reserved. They give a zero result and fmask 0, and leave `prod` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Request strobe |
| op | input | 5 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second operand (register or immediate) |
| stat_in | input | 5 | Current condition word {N,OV,Z,DC,C} |
| result | output | 8 | Byte result |
| flags | output | 5 | Merged condition word after the operation |
| fmask | output | 5 | Condition bits written by the operation |
| done | output | 1 | Result valid, one cycle after the request |
| prod | output | 16 | Product register |

## Verification
Two things happen in the same cycle and are the main risk. One is the new value of each written condition bit. The other is the pass-through of the bits the operation leaves alone, so a wrong mask shows up only when `stat_in` differs from the computed value. The sweep varies `stat_in` together with both operands on every code, so each bit position sees both cases. The product register is likewise compared after every request of every other code, to catch a multiply that leaks a write while a different operation owns the cycle.

// File: rtl/byte_alu.sv
module byte_alu #(
  parameter int DW  = 8,
  parameter int OPW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [OPW-1:0]  op,
  input  logic [DW-1:0]   acc,
  input  logic [DW-1:0]   opnd,
  input  logic [4:0]      stat_in,
  output logic [DW-1:0]   result,
  output logic [4:0]      flags,
  output logic [4:0]      fmask,
  output logic            done,
  output logic [2*DW-1:0] prod
);
  localparam int NW     = DW / 2;
  localparam int PW     = 2 * DW;
  localparam int DIGMAX = 9;

  localparam logic [OPW-1:0] OP_ADD   = OPW'(0);
  localparam logic [OPW-1:0] OP_ADDC  = OPW'(1);
  localparam logic [OPW-1:0] OP_SUB   = OPW'(2);
  localparam logic [OPW-1:0] OP_SUBB  = OPW'(3);
  localparam logic [OPW-1:0] OP_RSUBB = OPW'(4);
  localparam logic [OPW-1:0] OP_INC   = OPW'(5);
  localparam logic [OPW-1:0] OP_DEC   = OPW'(6);
  localparam logic [OPW-1:0] OP_NEG   = OPW'(7);
  localparam logic [OPW-1:0] OP_AND   = OPW'(8);
  localparam logic [OPW-1:0] OP_OR    = OPW'(9);
  localparam logic [OPW-1:0] OP_XOR   = OPW'(10);
  localparam logic [OPW-1:0] OP_COM   = OPW'(11);
  localparam logic [OPW-1:0] OP_MOV   = OPW'(12);
  localparam logic [OPW-1:0] OP_RL    = OPW'(13);
  localparam logic [OPW-1:0] OP_RR    = OPW'(14);
  localparam logic [OPW-1:0] OP_RLC   = OPW'(15);
  localparam logic [OPW-1:0] OP_RRC   = OPW'(16);
  localparam logic [OPW-1:0] OP_SWAP  = OPW'(17);
  localparam logic [OPW-1:0] OP_DAW   = OPW'(18);
  localparam logic [OPW-1:0] OP_MUL   = OPW'(19);

  localparam logic [4:0] M_ALL  = 5'b11111;
  localparam logic [4:0] M_NZ   = 5'b10100;
  localparam logic [4:0] M_NZC  = 5'b10101;
  localparam logic [4:0] M_C    = 5'b00001;
  localparam logic [4:0] M_NONE = 5'b00000;

  localparam logic [DW:0] ADJ_LO = (DW+1)'(6);
  localparam logic [DW:0] ADJ_HI = ADJ_LO << NW;

  wire c_in  = stat_in[0];
  wire dc_in = stat_in[1];

  logic [DW-1:0] ax, ay;
  logic          ci;

  always_comb begin
    ax = opnd;
    ay = '0;
    ci = 1'b0;
    case (op)
      OP_ADD:   ay = acc;
      OP_ADDC:  begin ay = acc;   ci = c_in; end
      OP_SUB:   begin ay = ~acc;  ci = 1'b1; end
      OP_SUBB:  begin ay = ~acc;  ci = c_in; end
      OP_RSUBB: begin ax = acc;   ay = ~opnd; ci = c_in; end
      OP_INC:   ci = 1'b1;
      OP_DEC:   ay = '1;
      OP_NEG:   begin ax = '0;    ay = ~opnd; ci = 1'b1; end
      default:  ;
    endcase
  end

  wire [DW:0] sum  = {1'b0, ax} + {1'b0, ay} + {{DW{1'b0}}, ci};
  wire [NW:0] lsum = {1'b0, ax[NW-1:0]} + {1'b0, ay[NW-1:0]} + {{NW{1'b0}}, ci};
  wire        ovf  = (ax[DW-1] == ay[DW-1]) && (sum[DW-1] != ax[DW-1]);

  wire        lo_fix = (acc[NW-1:0] > NW'(DIGMAX)) || dc_in;
  wire [DW:0] dstep  = {1'b0, acc} + (lo_fix ? ADJ_LO : '0);
  wire        hi_fix = (dstep[DW-1:NW] > (DW-NW)'(DIGMAX)) || c_in;
  wire [DW:0] dfin   = dstep + (hi_fix ? ADJ_HI : '0);

  wire [PW-1:0] mul = PW'(acc) * PW'(opnd);

  logic [DW-1:0] res;
  logic          cnew;
  logic [4:0]    msk;

  always_comb begin
    res  = sum[DW-1:0];
    cnew = sum[DW];
    msk  = M_NONE;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB,
      OP_RSUBB, OP_INC, OP_DEC, OP_NEG: msk = M_ALL;
      OP_AND:  begin res = acc & opnd; msk = M_NZ; end
      OP_OR:   begin res = acc | opnd; msk = M_NZ; end
      OP_XOR:  begin res = acc ^ opnd; msk = M_NZ; end
      OP_COM:  begin res = ~opnd;      msk = M_NZ; end
      OP_MOV:  begin res = opnd;       msk = M_NZ; end
      OP_RL:   begin res = {opnd[DW-2:0], opnd[DW-1]}; msk = M_NZ; end
      OP_RR:   begin res = {opnd[0], opnd[DW-1:1]};    msk = M_NZ; end
      OP_RLC:  begin res = {opnd[DW-2:0], c_in}; cnew = opnd[DW-1]; msk = M_NZC; end
      OP_RRC:  begin res = {c_in, opnd[DW-1:1]}; cnew = opnd[0];    msk = M_NZC; end
      OP_SWAP: res = {opnd[NW-1:0], opnd[DW-1:NW]};
      OP_DAW:  begin res = dfin[DW-1:0]; cnew = c_in | dfin[DW]; msk = M_C; end
      OP_MUL:  res = mul[DW-1:0];
      default: res = '0;
    endcase
  end

  wire [4:0] fnew = {res[DW-1], ovf, res == '0, lsum[NW], cnew};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      flags  <= '0;
      fmask  <= '0;
      done   <= 1'b0;
      prod   <= '0;
    end else begin
      done <= go;
      if (go) begin
        result <= res;
        flags  <= (fnew & msk) | (stat_in & ~msk);
        fmask  <= msk;
        if (op == OP_MUL) prod <= mul;
      end
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int DW  = 8,
  parameter int OPW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            go,
  input logic [OPW-1:0]  op,
  input logic [4:0]      stat_in,
  input logic [DW-1:0]   result,
  input logic [4:0]      flags,
  input logic [4:0]      fmask,
  input logic            done,
  input logic [2*DW-1:0] prod
);
  localparam logic [OPW-1:0] C_DAW = OPW'(18);
  localparam logic [OPW-1:0] C_MUL = OPW'(19);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done == ($past(go) && $past(rst_n)));

  p_prod_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !($past(go) && $past(op) == C_MUL)) |-> $stable(prod));

  p_passthru_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && done) |-> (((flags ^ $past(stat_in)) & ~fmask) == 5'b0));

  p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fmask[2]) |-> (flags[2] == (result == '0)));

  p_sign_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fmask[4]) |-> (flags[4] == result[DW-1]));

  p_daw_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && done && $past(op) == C_DAW && $past(stat_in[0])) |-> flags[0]);
endmodule

bind byte_alu byte_alu_chk #(.DW(DW), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .op(op), .stat_in(stat_in),
  .result(result), .flags(flags), .fmask(fmask), .done(done), .prod(prod)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  acc = '0;
  logic [7:0]  opnd = '0;
  logic [4:0]  stat_in = '0;
  logic [7:0]  result;
  logic [4:0]  flags;
  logic [4:0]  fmask;
  logic        done;
  logic [15:0] prod;

  int nchk = 0;
  int nerr = 0;
  int exp_prod = 0;

  always #10 clk = ~clk;

  byte_alu uut (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .acc(acc), .opnd(opnd),
    .stat_in(stat_in), .result(result), .flags(flags), .fmask(fmask),
    .done(done), .prod(prod)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic void add_ref(input int x, input int y, input int ci,
      output int r, output int cf, output int dcf, output int ovf);
    int sr;
    r   = x + y + ci;
    cf  = (r > 255) ? 1 : 0;
    dcf = ((x & 15) + (y & 15) + ci > 15) ? 1 : 0;
    sr  = sx(x) + sx(y) + ci;
    ovf = (sr > 127 || sr < -128) ? 1 : 0;
    r   = r & 255;
  endfunction

  function automatic void sub_ref(input int x, input int y, input int bw,
      output int r, output int cf, output int dcf, output int ovf);
    int sr;
    r   = x - y - bw;
    cf  = (r >= 0) ? 1 : 0;
    dcf = ((x & 15) - (y & 15) - bw >= 0) ? 1 : 0;
    sr  = sx(x) - sx(y) - bw;
    ovf = (sr > 127 || sr < -128) ? 1 : 0;
    r   = r & 255;
  endfunction

  function automatic void model(input int o, input int a, input int b, input int s,
      output int res, output int nf, output int m);
    int c, dc, cf, dcf, ovf, v;
    c = s & 1; dc = (s >> 1) & 1;
    cf = 0; dcf = 0; ovf = 0; res = 0; m = 0;
    case (o)
      0:  begin add_ref(b, a, 0, res, cf, dcf, ovf); m = 31; end
      1:  begin add_ref(b, a, c, res, cf, dcf, ovf); m = 31; end
      2:  begin sub_ref(b, a, 0, res, cf, dcf, ovf); m = 31; end
      3:  begin sub_ref(b, a, 1 - c, res, cf, dcf, ovf); m = 31; end
      4:  begin sub_ref(a, b, 1 - c, res, cf, dcf, ovf); m = 31; end
      5:  begin add_ref(b, 1, 0, res, cf, dcf, ovf); m = 31; end
      6:  begin sub_ref(b, 1, 0, res, cf, dcf, ovf); m = 31; end
      7:  begin sub_ref(0, b, 0, res, cf, dcf, ovf); m = 31; end
      8:  begin res = a & b; m = 20; end
      9:  begin res = a | b; m = 20; end
      10: begin res = a ^ b; m = 20; end
      11: begin res = 255 - b; m = 20; end
      12: begin res = b; m = 20; end
      13: begin res = ((b * 2) & 255) | (b / 128); m = 20; end
      14: begin res = (b / 2) | ((b & 1) * 128); m = 20; end
      15: begin res = ((b * 2) & 255) | c; cf = b / 128; m = 21; end
      16: begin res = (b / 2) | (c * 128); cf = b & 1; m = 21; end
      17: begin res = ((b & 15) * 16) | (b / 16); m = 0; end
      18: begin
        v = a;
        if ((v & 15) > 9 || dc == 1) v = v + 6;
        if (((v >> 4) & 15) > 9 || c == 1) v = v + 96;
        cf = (c == 1 || v > 255) ? 1 : 0;
        res = v & 255; m = 1;
      end
      19: begin res = (a * b) & 255; m = 0; end
      default: begin res = 0; m = 0; end
    endcase
    nf = ((res >> 7) << 4) | (ovf << 3) | ((res == 0 ? 1 : 0) << 2) | (dcf << 1) | cf;
  endfunction

  function automatic string req_of(input int o);
    if (o == 0 || o == 1 || o == 5) return "R2";
    if (o >= 2 && o <= 7) return "R3";
    if (o >= 8 && o <= 12) return "R5";
    if (o >= 13 && o <= 16) return "R6";
    if (o == 17) return "R7";
    if (o == 18) return "R8";
    if (o == 19) return "R9";
    return "R12";
  endfunction

  task automatic run_vec(input int o, input int a, input int b, input int s);
    int er, enf, em, ef;
    go = 1'b1; op = 5'(o); acc = 8'(a); opnd = 8'(b); stat_in = 5'(s);
    @(negedge clk);
    model(o, a, b, s, er, enf, em);
    ef = (enf & em) | (s & ~em & 31);
    if (o == 19) exp_prod = a * b;
    check(result == 8'(er), $sformatf("%s result op=%0d a=%0h b=%0h", req_of(o), o, a, b), result, er);
    check(flags == 5'(ef), $sformatf("R11 %s flags op=%0d a=%0h b=%0h s=%0h", req_of(o), o, a, b, s), flags, ef);
    check(fmask == 5'(em), $sformatf("%s mask op=%0d", (o <= 7) ? "R4" : req_of(o), o), fmask, em);
    check(done == 1'b1, "R1 done after request", done, 1);
    check(prod == 16'(exp_prod), $sformatf("R10 prod op=%0d", o), prod, exp_prod);
  endtask

  int alist[12] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h39, 8'h99, 8'h5A};

  initial begin
    repeat (4) @(negedge clk);
    check(result == 8'h00 && flags == 5'h00 && fmask == 5'h00 && prod == 16'h0 && done == 1'b0,
          "R1 reset state", {result, flags}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && result == 8'h00, "R1 idle after reset", {done, result}, 0);

    for (int o = 0; o < 32; o++)
      for (int ai = 0; ai < 12; ai++)
        for (int b = 0; b < 256; b++)
          run_vec(o, alist[ai], b, (b ^ (ai * 11) ^ (o * 5)) & 31);

    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 32; s++)
        run_vec(18, a, a ^ 8'h3C, s);

    run_vec(19, 8'hFF, 8'hFF, 0);
    check(prod == 16'hFE01, "R9 full product", prod, 16'hFE01);
    run_vec(17, 8'hA5, 8'hC3, 5'h1F);
    check(result == 8'h3C && flags == 5'h1F, "R7 swap keeps status", {result, flags}, 16'h3C1F);

    go = 1'b0; acc = 8'h12; opnd = 8'h34; op = 5'd0; stat_in = 5'h0A;
    @(negedge clk);
    check(done == 1'b0, "R1 done drops without go", done, 0);
    check(result == 8'h3C && flags == 5'h1F && fmask == 5'h00, "R1 outputs hold without go",
          {result, flags}, 16'h3C1F);
    check(prod == 16'hFE01, "R10 prod holds when idle", prod, 16'hFE01);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule